// File: doc/BRIEF.md
# Atomic Memory Read-Modify-Write Unit

This unit carries out one atomic store-class instruction at a time against a simple synchronous memory port. A decoded request gives an access width, an 8-bit operation byte, a base address with a signed 16-bit displacement, the source-register value and the accumulator (R0) value. The unit then works through a locked read, compute and conditional write sequence. It finishes with a one-cycle completion pulse. That pulse carries either a register write-back, meaning a value plus a selector that says whether it goes to the source register or to R0, or an illegal-operation flag.

The operation byte reuses arithmetic op codes, and its lowest bit asks for the old memory value to be returned. Swap and compare-and-swap always return the old value. Compare-and-swap compares against R0 implicitly and returns its result to R0. Memory read data arrives one cycle after a read is issued. A write takes effect at the clock edge that ends the write cycle. The lock output marks the span during which no other agent may touch memory.

Top module: `amo_rmw_unit`

## Requirements
- R1: A width code of 0 (8-bit) or 1 (16-bit) is rejected. One cycle after acceptance the unit pulses `done` with `illegal` high, and it issues no read, no write and no lock.
- R2: The memory address is `req_base` plus `req_off` sign-extended to the address width.
- R3: Simple operations write old-value OP source-value back to memory. The operation byte selects OP, ignoring bit 0: 0x00 add, 0x40 or, 0x50 and, 0xa0 xor.
- R4: Bit 0 of the operation byte requests the old value. When it is set on a simple operation, `wb_valid` is high with `done`, `wb_to_acc` is 0 and `wb_data` carries the old memory value. When it is clear, `wb_valid` stays low.
- R5: Operation byte 0xe1 (swap) writes the source value to memory and returns the old value to the source register (`wb_to_acc` 0).
- R6: Operation byte 0xf1 (compare-and-swap) writes the source value only when the memory value equals the accumulator. In both cases it returns the old value, zero-extended, with `wb_to_acc` 1.
- R7: Operation bytes 0xe0, 0xf0 and every byte not listed in R3, R5 or R6 (bit 0 ignored for R3) are illegal. They produce `illegal` with no memory access and no write-back.
- R8: With width code 2 (32-bit), only the low 32 bits of every operand are used, including the comparison. The upper half of `mem_wdata` and of `wb_data` is zero, and `mem_wide` is low. Width code 3 is the 64-bit mode and drives `mem_wide` high.
- R9: A legal request issues exactly one read in the cycle after acceptance. `done` follows two cycles later in the same cycle as the single optional write. `mem_lock` is high for all three cycles, including a failed compare, and `done` lasts one cycle.
- R10: `req_ready` is low from acceptance until `done`, and requests presented meanwhile are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_size | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| req_imm | input | 8 | Operation byte |
| req_base | input | ADDR_W | Base address |
| req_off | input | OFF_W | Signed displacement |
| req_src | input | DATA_W | Source-register value |
| req_acc | input | DATA_W | Accumulator (R0) value |
| mem_lock | output | 1 | Memory held for this unit |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wide | output | 1 | Access is full width (else low half) |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd_en` |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Request rejected (with `done`) |
| wb_valid | output | 1 | Register write-back present (with `done`) |
| wb_to_acc | output | 1 | Write-back goes to R0 instead of source register |
| wb_data | output | DATA_W | Write-back value |

## Verification
The bench goes after the half-width path with a carry that crosses bit 31 and a compare whose upper halves differ while the low halves match. A unit that kept the upper bits would corrupt the neighbouring word, return a sign-polluted old value or miss the match. It exercises compare-and-swap both ways and counts lock cycles and writes. A design that dropped the lock early or wrote on a mismatch would show the wrong count. The 0xe0/0xf0 forms, unknown bytes and the narrow widths are sent to confirm that no read or write slips out. A negative displacement and a second request presented mid-sequence expose a zero-extended offset and a unit that re-accepts while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } amo_width_e;

    typedef enum logic [2:0] {
        K_ADD  = 3'd0,
        K_OR   = 3'd1,
        K_AND  = 3'd2,
        K_XOR  = 3'd3,
        K_SWAP = 3'd4,
        K_CAS  = 3'd5
    } amo_kind_e;

    localparam logic [6:0] CODE_ADD  = 7'h00;  // byte 0x00
    localparam logic [6:0] CODE_OR   = 7'h20;  // byte 0x40
    localparam logic [6:0] CODE_AND  = 7'h28;  // byte 0x50
    localparam logic [6:0] CODE_XOR  = 7'h50;  // byte 0xa0
    localparam logic [6:0] CODE_SWAP = 7'h70;  // byte 0xe0
    localparam logic [6:0] CODE_CAS  = 7'h78;  // byte 0xf0

    typedef struct packed {
        logic      legal;
        amo_kind_e kind;
        logic      fetch;
        logic      wide;
    } amo_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_CALC  = 3'd2,
        ST_WRITE = 3'd3,
        ST_FAULT = 3'd4
    } amo_state_e;

    // Swap and compare-and-swap are only defined with the fetch bit set.
    function automatic logic amo_fetch_required(amo_kind_e k);
        return (k == K_SWAP) || (k == K_CAS);
    endfunction

endpackage

// File: rtl/amo_decoder.sv
module amo_decoder
    import amo_pkg::*;
(
    input  logic [1:0] size,
    input  logic [7:0] imm,
    output amo_ctl_t   ctl
);
    logic      known;
    amo_kind_e kind;
    logic      size_ok;

    always_comb begin
        known = 1'b1;
        kind  = K_ADD;
        unique case (imm[7:1])
            CODE_ADD:  kind = K_ADD;
            CODE_OR:   kind = K_OR;
            CODE_AND:  kind = K_AND;
            CODE_XOR:  kind = K_XOR;
            CODE_SWAP: kind = K_SWAP;
            CODE_CAS:  kind = K_CAS;
            default:   known = 1'b0;
        endcase
    end

    assign size_ok = (size == WID_32) || (size == WID_64);

    always_comb begin
        ctl.kind  = kind;
        ctl.fetch = imm[0];
        ctl.wide  = (size == WID_64);
        ctl.legal = known && size_ok && (imm[0] || !amo_fetch_required(kind));
    end
endmodule

// File: rtl/amo_agen.sv
module amo_agen #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_sx;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_sx = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_sx = off[ADDR_W-1:0];
        end
    endgenerate

    assign addr = base + off_sx;
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_kind_e         kind,
    input  logic              wide,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] acc_val,
    output logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] old_ext,
    output logic              do_write
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] old_n, src_n, acc_n, res;
    logic              match;

    function automatic logic [DATA_W-1:0] fit(input logic w, input logic [DATA_W-1:0] v);
        return w ? v : {{(DATA_W-HALF){1'b0}}, v[HALF-1:0]};
    endfunction

    assign old_n = fit(wide, old_val);
    assign src_n = fit(wide, src_val);
    assign acc_n = fit(wide, acc_val);

    always_comb begin
        unique case (kind)
            K_ADD:   res = old_n + src_n;
            K_OR:    res = old_n | src_n;
            K_AND:   res = old_n & src_n;
            K_XOR:   res = old_n ^ src_n;
            default: res = src_n;
        endcase
    end

    assign match    = (old_n == acc_n);
    assign new_val  = fit(wide, res);
    assign old_ext  = old_n;
    assign do_write = (kind != K_CAS) || match;
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic [7:0]        req_imm,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_src,
    input  logic [DATA_W-1:0] req_acc,
    output logic              mem_lock,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic              wb_valid,
    output logic              wb_to_acc,
    output logic [DATA_W-1:0] wb_data
);
    amo_state_e        st;
    amo_ctl_t          ctl_d, ctl_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [DATA_W-1:0] src_q, acc_q, old_q;
    logic [DATA_W-1:0] new_val, old_ext;
    logic              do_write;
    logic              accept;

    amo_decoder i_dec (
        .size (req_size),
        .imm  (req_imm),
        .ctl  (ctl_d)
    );

    amo_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_agen (
        .base (req_base),
        .off  (req_off),
        .addr (addr_d)
    );

    amo_alu #(.DATA_W(DATA_W)) i_alu (
        .kind     (ctl_q.kind),
        .wide     (ctl_q.wide),
        .old_val  (old_q),
        .src_val  (src_q),
        .acc_val  (acc_q),
        .new_val  (new_val),
        .old_ext  (old_ext),
        .do_write (do_write)
    );

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ctl_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            acc_q  <= '0;
            old_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_q  <= ctl_d;
                        addr_q <= addr_d;
                        src_q  <= req_src;
                        acc_q  <= req_acc;
                        st     <= ctl_d.legal ? ST_READ : ST_FAULT;
                    end
                end
                ST_READ:  st <= ST_CALC;
                ST_CALC: begin
                    old_q <= mem_rdata;
                    st    <= ST_WRITE;
                end
                ST_WRITE: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_lock  = (st == ST_READ) || (st == ST_CALC) || (st == ST_WRITE);
        mem_rd_en = (st == ST_READ);
        mem_wr_en = (st == ST_WRITE) && do_write;
        mem_wide  = ctl_q.wide;
        mem_addr  = addr_q;
        mem_wdata = new_val;
        done      = (st == ST_WRITE) || (st == ST_FAULT);
        illegal   = (st == ST_FAULT) && !ctl_q.legal;
        wb_valid  = (st == ST_WRITE) && ctl_q.fetch;
        wb_to_acc = (st == ST_WRITE) && (ctl_q.kind == K_CAS);
        wb_data   = old_ext;
    end
endmodule

// File: rtl/amo_rmw_checker.sv
module amo_rmw_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_lock,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              mem_wide,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done,
    input logic              illegal,
    input logic              wb_valid,
    input logic              wb_to_acc,
    input logic [DATA_W-1:0] wb_data
);
    localparam int HALF = DATA_W / 2;

    p_illegal_no_mem_r1: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_rd_en && !mem_wr_en && !mem_lock && done));

    p_fetch_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

    p_cas_result_r6: assert property (@(posedge clk) disable iff (rst)
        wb_to_acc |-> (wb_valid && done));

    p_illegal_no_wb_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wb_valid && !wb_to_acc));

    p_narrow_wdata_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_wide) |-> (mem_wdata[DATA_W-1:HALF] == '0));

    p_narrow_wb_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !mem_wide) |-> (wb_data[DATA_W-1:HALF] == '0));

    p_read_locked_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> mem_lock);

    p_write_locked_r9: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_lock && done));

    p_read_to_done_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ##2 (done && !illegal && mem_lock));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        mem_lock |-> !req_ready);
endmodule

bind amo_rmw_unit amo_rmw_checker #(.DATA_W(DATA_W)) i_amo_rmw_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_lock  (mem_lock),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wide  (mem_wide),
    .mem_wdata (mem_wdata),
    .done      (done),
    .illegal   (illegal),
    .wb_valid  (wb_valid),
    .wb_to_acc (wb_to_acc),
    .wb_data   (wb_data)
);

// File: tb/test_amo_rmw_unit.sv
module test_amo_rmw_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [1:0]  req_size;
    logic [7:0]  req_imm;
    logic [63:0] req_base, req_src, req_acc;
    logic [15:0] req_off;
    logic        mem_lock, mem_rd_en, mem_wr_en, mem_wide;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, illegal, wb_valid, wb_to_acc;
    logic [63:0] wb_data;

    always #5 clk = ~clk;

    amo_rmw_unit i_amo_rmw_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_imm(req_imm), .req_base(req_base),
        .req_off(req_off), .req_src(req_src), .req_acc(req_acc),
        .mem_lock(mem_lock), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
        .wb_valid(wb_valid), .wb_to_acc(wb_to_acc), .wb_data(wb_data)
    );

    // byte-addressed model, little-endian, indexed by the low address byte
    logic [7:0] mem_q [0:255];

    always @(posedge clk) begin
        if (mem_rd_en)
            for (int i = 0; i < 8; i++)
                mem_rdata[8*i +: 8] <= mem_q[8'(mem_addr[7:0] + 8'(i))];
        if (mem_wr_en)
            for (int i = 0; i < (mem_wide ? 8 : 4); i++)
                mem_q[8'(mem_addr[7:0] + 8'(i))] <= mem_wdata[8*i +: 8];
    end

    int checks = 0;
    int fails  = 0;

    int          n_rd, n_wr, n_lock, lat, late_acc;
    logic [63:0] last_addr, last_wdata, r_wb;
    logic        r_ill, r_wbv, r_acc, busy_ready;
    bit          seen_done;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic put64(input logic [7:0] a, input logic [63:0] v);
        for (int i = 0; i < 8; i++) mem_q[8'(a + 8'(i))] = v[8*i +: 8];
    endtask

    function automatic logic [63:0] get64(input logic [7:0] a);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = mem_q[8'(a + 8'(i))];
        return v;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [7:0] imm,
                          input logic [63:0] base, input logic [15:0] off,
                          input logic [63:0] src, input logic [63:0] acc,
                          input bit poke);
        n_rd = 0; n_wr = 0; n_lock = 0; lat = 0; late_acc = 0;
        seen_done = 0; busy_ready = 1'b1;
        r_ill = 0; r_wbv = 0; r_acc = 0; r_wb = '0;
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_imm = imm;
        req_base = base; req_off = off; req_src = src; req_acc = acc;
        for (int c = 1; c <= 8 && !seen_done; c++) begin
            @(negedge clk);
            if (c == 1) begin
                req_valid = poke;
                if (poke) begin
                    busy_ready = req_ready;
                    req_imm = 8'he1; req_src = 64'hDEAD; req_off = 16'h0008;
                end
            end
            if (c == 2) req_valid = 1'b0;
            if (mem_rd_en) begin n_rd++; last_addr = mem_addr; end
            if (mem_wr_en) begin n_wr++; last_wdata = mem_wdata; end
            if (mem_lock) n_lock++;
            if (done) begin
                seen_done = 1; lat = c;
                r_ill = illegal; r_wbv = wb_valid; r_acc = wb_to_acc; r_wb = wb_data;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        if (mem_rd_en || mem_wr_en || mem_lock) late_acc++;
    endtask

    task automatic t_reset();
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        chk("R9 no lock after reset", 64'(mem_lock), 64'd0);
        chk("R9 no done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_narrow_sizes();
        for (int s = 0; s < 2; s++) begin
            put64(8'h10, 64'h0123_4567_89AB_CDEF);
            run_op(2'(s), 8'h01, 64'h10, 16'h0, 64'h5, 64'h0, 0);
            chk("R1 illegal flag", 64'(r_ill), 64'd1);
            chk("R1 one-cycle reject", 64'(lat), 64'd1);
            chk("R1 no access", 64'(n_rd + n_wr + n_lock + late_acc), 64'd0);
            chk("R1 memory intact", get64(8'h10), 64'h0123_4567_89AB_CDEF);
        end
    endtask

    task automatic t_addr();
        put64(8'h70, 64'h0);
        run_op(2'd3, 8'h00, 64'h1234_0000_0000_0090, 16'hFFE0, 64'h1, 64'h0, 0);
        chk("R2 negative displacement", last_addr, 64'h1234_0000_0000_0070);
        run_op(2'd3, 8'h00, 64'h40, 16'h0010, 64'h1, 64'h0, 0);
        chk("R2 positive displacement", last_addr, 64'h50);
    endtask

    task automatic t_simple();
        logic [63:0] o, s, e;
        logic [7:0]  code;
        o = 64'hF0F0_1234_8000_00FF;
        s = 64'h0FF0_0001_8000_0F01;
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: begin code = 8'h00; e = o + s; end
                1: begin code = 8'h40; e = o | s; end
                2: begin code = 8'h50; e = o & s; end
                default: begin code = 8'hA0; e = o ^ s; end
            endcase
            put64(8'h80, o);
            run_op(2'd3, code, 64'h80, 16'h0, s, 64'h0, 0);
            chk("R3 memory result", get64(8'h80), e);
            chk("R3 one write", 64'(n_wr), 64'd1);
            chk("R4 no write-back without fetch", 64'(r_wbv), 64'd0);
            chk("R9 latency", 64'(lat), 64'd3);
        end
    endtask

    task automatic t_fetch();
        put64(8'h88, 64'h1000_0000_0000_0003);
        run_op(2'd3, 8'h41, 64'h88, 16'h0, 64'h0000_0000_0000_0030, 64'h0, 0);
        chk("R4 wb valid", 64'(r_wbv), 64'd1);
        chk("R4 to source", 64'(r_acc), 64'd0);
        chk("R4 old value", r_wb, 64'h1000_0000_0000_0003);
        chk("R3 or with fetch", get64(8'h88), 64'h1000_0000_0000_0033);
    endtask

    task automatic t_swap();
        put64(8'h90, 64'hAAAA_0000_BBBB_0000);
        run_op(2'd3, 8'hE1, 64'h90, 16'h0, 64'h1111_2222_3333_4444, 64'h0, 0);
        chk("R5 memory gets source", get64(8'h90), 64'h1111_2222_3333_4444);
        chk("R5 old to source", r_wb, 64'hAAAA_0000_BBBB_0000);
        chk("R5 selector", 64'({r_wbv, r_acc}), 64'b10);
    endtask

    task automatic t_cas();
        put64(8'h98, 64'h0000_0000_0000_0777);
        run_op(2'd3, 8'hF1, 64'h98, 16'h0, 64'h0000_0000_0000_0999, 64'h777, 0);
        chk("R6 match writes", get64(8'h98), 64'h999);
        chk("R6 match old to R0", r_wb, 64'h777);
        chk("R6 R0 selector", 64'({r_wbv, r_acc}), 64'b11);
        run_op(2'd3, 8'hF1, 64'h98, 16'h0, 64'h0000_0000_0000_0555, 64'h777, 0);
        chk("R6 mismatch no write", 64'(n_wr), 64'd0);
        chk("R6 mismatch memory intact", get64(8'h98), 64'h999);
        chk("R6 mismatch old to R0", r_wb, 64'h999);
        chk("R6 mismatch selector", 64'(r_acc), 64'd1);
        chk("R9 lock through failed compare", 64'(n_lock), 64'd3);
        chk("R9 single read", 64'(n_rd), 64'd1);
    endtask

    task automatic t_bad_imm();
        logic [7:0] bad [4] = '{8'hE0, 8'hF0, 8'h10, 8'h82};
        for (int k = 0; k < 4; k++) begin
            put64(8'hA0, 64'h5A5A_5A5A_5A5A_5A5A);
            run_op(2'd3, bad[k], 64'hA0, 16'h0, 64'h1, 64'h5A5A_5A5A_5A5A_5A5A, 0);
            chk("R7 illegal flag", 64'(r_ill), 64'd1);
            chk("R7 no memory access", 64'(n_rd + n_wr), 64'd0);
            chk("R7 no write-back", 64'(r_wbv), 64'd0);
            chk("R7 memory intact", get64(8'hA0), 64'h5A5A_5A5A_5A5A_5A5A);
        end
    endtask

    task automatic t_w32();
        put64(8'h20, 64'hAAAA_BBBB_FFFF_FFFF);
        run_op(2'd2, 8'h01, 64'h20, 16'h0, 64'h0000_0001_0000_0002, 64'h0, 0);
        chk("R8 carry stays in low half", get64(8'h20), 64'hAAAA_BBBB_0000_0001);
        chk("R8 write data zero-extended", last_wdata, 64'h0000_0000_0000_0001);
        chk("R8 fetched value zero-extended", r_wb, 64'h0000_0000_FFFF_FFFF);
        put64(8'h30, 64'h5555_5555_1111_2222);
        run_op(2'd2, 8'hF1, 64'h30, 16'h0, 64'h7777_7777_3333_4444,
               64'h9999_9999_1111_2222, 0);
        chk("R8 compare on low half", get64(8'h30), 64'h5555_5555_3333_4444);
        chk("R8 compare result to R0", r_wb, 64'h0000_0000_1111_2222);
    endtask

    task automatic t_busy();
        put64(8'hB0, 64'h10);
        put64(8'hB8, 64'h77);
        run_op(2'd3, 8'h00, 64'hB0, 16'h0, 64'h5, 64'h0, 1);
        chk("R10 not ready while busy", 64'(busy_ready), 64'd0);
        chk("R10 single read", 64'(n_rd), 64'd1);
        chk("R10 single write", 64'(n_wr), 64'd1);
        chk("R10 no follow-on access", 64'(late_acc), 64'd0);
        chk("R10 first request result", get64(8'hB0), 64'h15);
        chk("R10 ignored request left memory", get64(8'hB8), 64'h77);
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_q[i] = 8'h00;
        rst = 1'b1; req_valid = 1'b0; req_size = '0; req_imm = '0;
        req_base = '0; req_off = '0; req_src = '0; req_acc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_narrow_sizes();
        t_addr();
        t_simple();
        t_fetch();
        t_swap();
        t_cas();
        t_bad_imm();
        t_w32();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule